// File: doc/BRIEF.md
# Byte-Level Two-Wire Bus Master with Acknowledge Wait

This block drives a two-wire bus (I2C) as master, one byte at a time, through open-drain clock and data lines. Software issues a start, writes bytes, reads bytes, and issues a stop. The block produces the START and STOP conditions on its own. It clocks out eight data bits MSB first and returns the slave's acknowledge in a status bit. As receiver it drives the acknowledge low itself. Flags report byte completion, start completion and arbitration loss. One flag-clear pulse clears all three.

An optional wait parks the clock low after the eighth data bit of every byte, before the acknowledge clock. The transfer-end flag rises on entry to this hold. The acknowledge clock runs only after software clears the flag. A second frame format, clocked synchronous serial, shifts eight bits with no START, no address phase and no acknowledge clock. In this format the clock idles high.

The clock comes from a quarter-period divider of the system clock. Each bit takes four quarters: two with the clock low, two with it high. Data changes in the second low quarter and is sampled in the middle of the high phase.

Top module: `i2cm_master`

## Requirements
- R1: After reset both line drivers are off (`scl_oe`=0, `sda_oe`=0) and `flag_tend`, `flag_start` and `flag_arb` are 0.
- R2: A `cmd_start` pulse in the two-wire format, while idle, pulls SDA low while SCL is high and then pulls SCL low. It then sets `flag_start`.
- R3: A `cmd_stop` pulse while holding the bus between bytes drives SDA low during SCL low, then releases SCL, then releases SDA while SCL is high. Both lines end released.
- R4: A `byte_go` pulse with `dir_rx`=0 sends `tx_byte` MSB first on eight SCL clocks and adds a ninth (acknowledge) clock. The line value sampled on the ninth clock goes to `rx_ack` (0 means acknowledged). `flag_tend` is set when the byte ends.
- R5: With `dir_rx`=1 the master leaves SDA released for eight clocks and assembles `rx_byte` MSB first. It drives SDA low on the ninth clock.
- R6: With `wait_en`=1, after the eighth rising SCL edge the master holds SCL low and sets `flag_tend`. No ninth clock appears while the flag stays set.
- R7: Clearing the flag during that wait releases SCL for the acknowledge clock. `rx_ack` is then updated and `flag_tend` is set again at the end of the byte.
- R8: With `mode_sync`=1, a `byte_go` pulse while idle gives exactly eight SCL clocks with the data MSB first. No START condition and no ninth clock occur, SCL is left high, and `flag_tend` is set.
- R9: If the master sends a 1 in the two-wire format but samples SDA low while SCL is high, it sets `flag_arb`. It releases both lines in the same cycle and returns to idle.
- R10: During data and acknowledge bits SDA changes only while SCL is low. SCL high and low phases each last 2*QDIV clock cycles.
- R11: A `flag_clr` pulse clears `flag_tend`, `flag_start` and `flag_arb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: generate START (two-wire format) |
| cmd_stop | input | 1 | Pulse: generate STOP |
| byte_go | input | 1 | Pulse: begin a byte transfer |
| tx_byte | input | DATA_W | Byte to send |
| dir_rx | input | 1 | 1 = receive the byte, 0 = send it |
| mode_sync | input | 1 | 1 = clocked synchronous serial, 0 = two-wire format |
| wait_en | input | 1 | Hold SCL low before the acknowledge clock |
| flag_clr | input | 1 | Pulse: clear all flags |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_byte | output | DATA_W | Last byte shifted in |
| rx_ack | output | 1 | Acknowledge sampled from the slave |
| flag_tend | output | 1 | Transfer-end flag |
| flag_start | output | 1 | START-complete flag |
| flag_arb | output | 1 | Arbitration-lost flag |

## Verification
With Q = QDIV cycles per quarter, START completes about 4Q+1 cycles after `cmd_start`. STOP completes 4Q cycles after `cmd_stop`. A byte without the wait raises `flag_tend` about 38Q cycles after `byte_go`. Arbitration loss is flagged 4Q cycles into the first bit. The bench samples START and STOP results after a fixed 4Q+4 window. It polls byte and arbitration flags with a bound of 40Q+8 cycles. It measures each SCL high and low phase against exactly 2Q cycles, so a slowed or skewed clock is caught. The wait scenario holds for 200 cycles and confirms that no ninth clock edge appears before the flag is cleared.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BIT, ST_WAIT, ST_ACK, ST_FIN, ST_STOP
  } i2cm_state_t;

  // a released (sent 1) line that reads low means another master won
  function automatic logic bit_lost(input logic sent, input logic seen);
    return sent & ~seen;
  endfunction

  function automatic logic quarter_last(input int unsigned cnt, input int unsigned per_q);
    return cnt == per_q - 1;
  endfunction
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int unsigned QDIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = i2cm_pkg::quarter_last(int'(cnt), QDIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned QDIV   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              byte_go,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              dir_rx,
  input  logic              mode_sync,
  input  logic              wait_en,
  input  logic              flag_clr,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_ack,
  output logic              flag_tend,
  output logic              flag_start,
  output logic              flag_arb
);
  import i2cm_pkg::*;

  localparam int unsigned BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  i2cm_state_t     state;
  logic [1:0]      q;
  logic [BCW-1:0]  bit_cnt;
  logic            sync_q, rx_q;
  logic            tick, tick_clr;
  logic            sh_load, sh_shift, sh_msb;
  logic [DATA_W-1:0] sh_q;

  // named events for the checker
  logic in_xfer, wait_hold, st_wait;
  assign st_wait   = (state == ST_WAIT);
  assign wait_hold = st_wait && (q != 2'd0);
  assign in_xfer   = (state == ST_BIT) || (state == ST_ACK);

  assign tick_clr = (state == ST_IDLE) || (state == ST_HOLD) || wait_hold;
  assign sh_load  = byte_go && (((state == ST_IDLE) && mode_sync) || (state == ST_HOLD));
  assign sh_shift = (state == ST_BIT) && tick && (q == 2'd3);
  assign sh_msb   = sh_q[DATA_W-1];

  i2cm_qtick #(.QDIV(QDIV)) u_qtick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
  );

  i2cm_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(sh_load),
    .load_val(dir_rx ? {DATA_W{1'b1}} : tx_byte),
    .shift(sh_shift), .sin(sda_in), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; q <= '0; bit_cnt <= '0;
      sync_q <= 1'b0; rx_q <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
      rx_byte <= '0; rx_ack <= 1'b0;
      flag_tend <= 1'b0; flag_start <= 1'b0; flag_arb <= 1'b0;
    end else begin
      if (flag_clr) begin
        flag_tend <= 1'b0; flag_start <= 1'b0; flag_arb <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          q <= '0;
          if (cmd_start && !mode_sync) begin
            state <= ST_START; sync_q <= 1'b0;
          end else if (byte_go && mode_sync) begin
            state <= ST_BIT; sync_q <= 1'b1; rx_q <= dir_rx; bit_cnt <= '0;
          end
        end
        ST_START: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd1) sda_oe <= 1'b1;
          if (q == 2'd3) begin
            scl_oe <= 1'b1; flag_start <= 1'b1; state <= ST_HOLD; q <= '0;
          end
        end
        ST_HOLD: begin
          if (byte_go) begin
            state <= ST_BIT; rx_q <= dir_rx; bit_cnt <= '0; q <= '0;
          end else if (cmd_stop) begin
            state <= ST_STOP; q <= '0;
          end
        end
        ST_BIT: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: scl_oe <= 1'b1;
            2'd1: sda_oe <= rx_q ? 1'b0 : ~sh_msb;
            2'd2: scl_oe <= 1'b0;
            default: begin
              if (!sync_q && !rx_q && bit_lost(sh_msb, sda_in)) begin
                flag_arb <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0;
                state <= ST_IDLE;
              end else if (bit_cnt == LAST_BIT) begin
                state <= sync_q ? ST_FIN : (wait_en ? ST_WAIT : ST_ACK);
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          endcase
        end
        ST_WAIT: begin
          if (q == 2'd0) begin
            if (tick) begin
              scl_oe <= 1'b1; flag_tend <= 1'b1; q <= 2'd1;
            end
          end else if (!flag_tend) begin
            state <= ST_ACK; q <= '0;
          end
        end
        ST_ACK: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: scl_oe <= 1'b1;
            2'd1: sda_oe <= rx_q;
            2'd2: scl_oe <= 1'b0;
            default: begin
              if (!rx_q) rx_ack <= sda_in;
              state <= ST_FIN;
            end
          endcase
        end
        ST_FIN: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd0 && !sync_q) scl_oe <= 1'b1;
          if (q == 2'd1) begin
            sda_oe <= 1'b0; flag_tend <= 1'b1; rx_byte <= sh_q; q <= '0;
            state <= sync_q ? ST_IDLE : ST_HOLD;
          end
        end
        ST_STOP: if (tick) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: state <= ST_IDLE;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_master_chk.sv
module i2cm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic flag_start,
  input logic flag_tend,
  input logic flag_arb,
  input logic in_xfer,
  input logic wait_hold,
  input logic st_wait
);
  // R10: data line moves only while the clock is held low inside a bit
  a_r10_sda_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && $past(in_xfer) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  // R6: the inserted wait keeps SCL pulled low
  a_r6_wait_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    wait_hold |-> scl_oe);

  // R7: acknowledge clock cannot begin while the flag is still set
  a_r7_wait_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_hold && flag_tend) |=> st_wait);

  // R9: arbitration loss leaves both lines released
  a_r9_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_arb) |-> (!scl_oe && !sda_oe));

  // R2: START flag appears with both lines pulled low
  a_r2_start_lines: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_start) |-> (scl_oe && sda_oe));
endmodule

bind i2cm_master i2cm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .flag_start(flag_start), .flag_tend(flag_tend), .flag_arb(flag_arb),
  .in_xfer(in_xfer), .wait_hold(wait_hold), .st_wait(st_wait)
);

// File: tb/i2cm_master_test.sv
`timescale 1ns/1ps
module i2cm_master_test;
  localparam int Q = 4;
  localparam int BYTE_LIMIT = 40*Q + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_stop = 0, byte_go = 0, dir_rx = 0;
  logic mode_sync = 0, wait_en = 0, flag_clr = 0;
  logic [7:0] tx_byte = 8'h00;
  logic scl_oe, sda_oe, rx_ack, flag_tend, flag_start, flag_arb;
  logic [7:0] rx_byte;

  // slave model controls
  logic slv_tx_en = 0, slv_ack_en = 0, slv_force = 0;
  logic [7:0] slv_byte = 8'h00;
  int fcnt = 0, bit_idx = 9;
  wire slv_low = (bit_idx < 8) ? (slv_tx_en & ~slv_byte[7-bit_idx])
               : ((bit_idx == 8) ? slv_ack_en : 1'b0);
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_low | slv_force);

  i2cm_master #(.DATA_W(8), .QDIV(Q)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .byte_go(byte_go), .tx_byte(tx_byte), .dir_rx(dir_rx),
    .mode_sync(mode_sync), .wait_en(wait_en), .flag_clr(flag_clr),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_byte(rx_byte),
    .rx_ack(rx_ack), .flag_tend(flag_tend), .flag_start(flag_start),
    .flag_arb(flag_arb)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rises = 0, starts = 0, stops = 0;
  int rise_cyc = 0, fall_cyc = 0, low_len = 0, high_len = 0;
  logic [15:0] hist = 16'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(posedge scl_line) begin
    rises++; hist = {hist[14:0], sda_line};
    low_len = cyc - fall_cyc; rise_cyc = cyc;
  end
  always @(negedge scl_line) begin
    high_len = cyc - rise_cyc; fall_cyc = cyc;
    bit_idx = fcnt; fcnt = (fcnt == 8) ? 0 : fcnt + 1;
  end
  always @(negedge sda_line) if (scl_line) begin starts++; fcnt = 0; bit_idx = 9; end
  always @(posedge sda_line) if (scl_line) stops++;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_tend();
    for (int i = 0; i < BYTE_LIMIT && !flag_tend; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    check(!flag_tend && !flag_start && !flag_arb, "R1 flags clear",
          {flag_tend, flag_start, flag_arb}, 0);
  endtask

  task automatic t_start();
    int s0 = starts;
    pulse(cmd_start); idle(4*Q + 4);
    check(starts == s0 + 1, "R2 START seen", starts - s0, 1);
    check(flag_start && scl_oe && sda_oe, "R2 flag and lines low",
          {flag_start, scl_oe, sda_oe}, 3'b111);
  endtask

  task automatic send(input logic [7:0] b, input logic ack, input logic rx);
    tx_byte = b; slv_ack_en = ack; dir_rx = rx;
    pulse(byte_go); wait_tend();
  endtask

  task automatic t_tx_ack();
    int r0 = rises;
    send(8'hA5, 1'b1, 1'b0);
    check(flag_tend, "R4 end flag", flag_tend, 1);
    check(rises == r0 + 9, "R4 nine clocks", rises - r0, 9);
    check(hist[8:1] == 8'hA5, "R4 MSB-first data", hist[8:1], 8'hA5);
    check(rx_ack == 1'b0, "R4 ack captured", rx_ack, 0);
    check(high_len == 2*Q && low_len == 2*Q, "R10 phase lengths",
          {high_len[15:0], low_len[15:0]}, {16'(2*Q), 16'(2*Q)});
    check(flag_start && flag_tend, "R11 flags set before clear", {flag_start, flag_tend}, 2'b11);
    pulse(flag_clr);
    check(!flag_start && !flag_tend, "R11 flags cleared", {flag_start, flag_tend}, 0);
  endtask

  task automatic t_tx_nack();
    send(8'h3C, 1'b0, 1'b0);
    check(rx_ack == 1'b1, "R4 nack captured", rx_ack, 1);
    check(hist[8:1] == 8'h3C, "R4 second pattern", hist[8:1], 8'h3C);
    pulse(flag_clr);
  endtask

  task automatic t_rx();
    slv_byte = 8'h96; slv_tx_en = 1'b1;
    send(8'h00, 1'b0, 1'b1);
    slv_tx_en = 1'b0;
    check(rx_byte == 8'h96, "R5 received byte", rx_byte, 8'h96);
    check(hist[0] == 1'b0, "R5 master ack low", hist[0], 0);
    pulse(flag_clr); dir_rx = 1'b0;
  endtask

  task automatic t_wait();
    int r0 = rises;
    wait_en = 1'b1;
    send(8'h5A, 1'b1, 1'b0);
    check(flag_tend && rises == r0 + 8, "R6 wait after eight clocks", rises - r0, 8);
    idle(200);
    check(rises == r0 + 8 && !scl_line, "R6 SCL held low", rises - r0, 8);
    check(hist[7:0] == 8'h5A, "R6 data before wait", hist[7:0], 8'h5A);
    pulse(flag_clr); wait_tend();
    check(flag_tend && rises == r0 + 9, "R7 ack clock after clear", rises - r0, 9);
    check(rx_ack == 1'b0, "R7 ack captured", rx_ack, 0);
    wait_en = 1'b0; pulse(flag_clr);
  endtask

  task automatic t_stop();
    int p0 = stops;
    pulse(cmd_stop); idle(4*Q + 4);
    check(stops == p0 + 1, "R3 STOP seen", stops - p0, 1);
    check(!scl_oe && !sda_oe, "R3 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_sync();
    int r0 = rises, s0 = starts;
    slv_ack_en = 1'b0; mode_sync = 1'b1; dir_rx = 1'b0; tx_byte = 8'hC3;
    pulse(byte_go); wait_tend(); idle(4*Q);
    check(flag_tend && rises == r0 + 8, "R8 eight clocks only", rises - r0, 8);
    check(hist[7:0] == 8'hC3, "R8 data", hist[7:0], 8'hC3);
    check(starts == s0 && scl_line, "R8 no START, SCL high", starts - s0, 0);
    mode_sync = 1'b0; pulse(flag_clr);
  endtask

  task automatic t_arb();
    int r0;
    pulse(cmd_start); idle(4*Q + 4); pulse(flag_clr);
    r0 = rises; slv_force = 1'b1; tx_byte = 8'h80; dir_rx = 1'b0;
    pulse(byte_go);
    for (int i = 0; i < BYTE_LIMIT && !flag_arb; i++) @(negedge clk);
    check(flag_arb, "R9 arbitration flag", flag_arb, 1);
    check(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
    check(rises == r0 + 1, "R9 stopped after first bit", rises - r0, 1);
    idle(8*Q);
    check(rises == r0 + 1, "R9 no further clocks", rises - r0, 1);
    slv_force = 1'b0; pulse(flag_clr);
    check(!flag_arb, "R11 arb flag cleared", flag_arb, 0);
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    t_reset();
    t_start();
    t_tx_ack();
    t_tx_nack();
    t_rx();
    t_wait();
    t_stop();
    t_sync();
    t_arb();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule